// File: doc/BRIEF.md
# Byte-Lane Data Memory

This block is a 32-bit-wide data store in which every address names one byte. A two-bit mode input picks one of four operations: an aligned word read, or a write of one byte, one halfword or one whole word. The low two address bits and the mode are decoded into four byte-lane enables that act on an internal word array of configurable depth, so a narrow write touches only its own lanes and leaves the rest of the word as it was.

Halfword and word writes must sit on their natural boundary. A write that breaks that rule is dropped and reported on a one-cycle error flag. Reads always return the whole aligned word. Choosing a byte or halfword out of it, and extending it, is left to the consumer.

Top module: `lane_mem`

## Requirements
- R1: After reset every stored word reads as zero and `alignErr` is low.
- R2: With `enable` high and `mode` = 00, `rdData` shows, in the same cycle, the word whose index is `addr[IDX_W+1:2]`. `addr[1:0]` has no effect on which word is returned.
- R3: With `enable` high and `mode` = 01, `wrData[7:0]` is stored at the rising edge into byte lane `addr[1:0]`. Lane 0 is word bits [7:0] and lane 3 is bits [31:24], which is little-endian order. The other three lanes keep their contents.
- R4: With `enable` high, `mode` = 10 and `addr[0]` = 0, `wrData[15:0]` is stored at the rising edge. It goes to word bits [15:0] when `addr[1]` = 0 and to bits [31:16] when `addr[1]` = 1. The other half keeps its contents.
- R5: With `enable` high, `mode` = 11 and `addr[1:0]` = 00, all 32 bits of `wrData` are stored at the rising edge.
- R6: A halfword write with `addr[0]` = 1, or a word write with `addr[1:0]` ≠ 00, leaves memory unchanged. It drives `alignErr` high for exactly the one cycle that follows the edge. `alignErr` is low after any edge that did not take such a write.
- R7: While `enable` is low, no memory is written, `rdData` is zero and `alignErr` stays low after the next edge, whatever the mode.
- R8: During a write cycle (`mode` ≠ 00), `rdData` is zero.
- R9: Word indexing wraps modulo DEPTH: address bits above `IDX_W+1` are ignored, so `addr` and `addr + 4*DEPTH` name the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Writes commit on its rising edge |
| rstN | input | 1 | Active-low synchronous reset. Clears the array and the flag |
| enable | input | 1 | Access enable. When low, nothing is read or written |
| mode | input | 2 | 00 word read, 01 byte write, 10 halfword write, 11 word write |
| addr | input | 32 | Byte address |
| wrData | input | 32 | Write data. Byte and halfword writes use its low bits |
| rdData | output | 32 | Combinational read word, zero when no read is active |
| alignErr | output | 1 | High for one cycle after a rejected misaligned write |

## Verification
A read returns its word in the same cycle, so the bench checks `rdData` shortly after it drives the inputs, in the middle of the cycle. A write becomes visible only after the next rising edge, and `alignErr` rises on that same edge. Each write item is therefore checked one half period after the edge that commits it, and the stored data is then read back in a later cycle. The bench keeps its own lane-wise model of the array, built from the requirements, and every expected value it queues comes from that model.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;

  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int OFS_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    MODE_RD_WORD = 2'b00,
    MODE_WR_BYTE = 2'b01,
    MODE_WR_HALF = 2'b10,
    MODE_WR_WORD = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    STEER_WORD = 2'b00,
    STEER_HALF = 2'b01,
    STEER_BYTE = 2'b10
  } steer_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic [LANES-1:0] laneEn;
    logic             rdEn;
    logic             errSet;
    steer_e           steer;
  } strobe_t;

endpackage

// File: rtl/lane_mem_ctrl.sv
module lane_mem_ctrl
  import lane_mem_pkg::*;
(
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic [OFS_W-1:0] lowAddr,
  output strobe_t          strobe
);

  logic [LANES-1:0] byteSel;
  logic [LANES-1:0] halfSel;
  logic             halfBad;
  logic             wordBad;

  // one-hot lane select for a single byte
  for (genvar l = 0; l < LANES; l++) begin : g_byteSel
    assign byteSel[l] = (lowAddr == OFS_W'(l));
  end

  // lower or upper pair of lanes, chosen by the half bit
  for (genvar l = 0; l < LANES; l++) begin : g_halfSel
    if (l < LANES / 2) begin : g_lo
      assign halfSel[l] = ~lowAddr[OFS_W-1];
    end else begin : g_hi
      assign halfSel[l] = lowAddr[OFS_W-1];
    end
  end

  assign halfBad = lowAddr[0];
  assign wordBad = |lowAddr;

  always_comb begin
    strobe        = '0;
    strobe.steer  = STEER_WORD;
    unique case (mode_e'(mode))
      MODE_RD_WORD: begin
        strobe.rdEn = enable;
      end
      MODE_WR_BYTE: begin
        strobe.steer  = STEER_BYTE;
        strobe.laneEn = enable ? byteSel : '0;
      end
      MODE_WR_HALF: begin
        strobe.steer  = STEER_HALF;
        strobe.errSet = enable & halfBad;
        strobe.laneEn = (enable & ~halfBad) ? halfSel : '0;
      end
      MODE_WR_WORD: begin
        strobe.steer  = STEER_WORD;
        strobe.errSet = enable & wordBad;
        strobe.laneEn = (enable & ~wordBad) ? '1 : '0;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/lane_mem_datapath.sv
module lane_mem_datapath
  import lane_mem_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              alignErr
);

  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] laneData;
  logic [WORD_W-1:0] rdWord;

  // replicate narrow data across every lane it may land in
  always_comb begin
    unique case (strobe.steer)
      STEER_BYTE: laneData = {LANES{wrData[BYTE_W-1:0]}};
      STEER_HALF: laneData = {2{wrData[HALF_W-1:0]}};
      default:    laneData = wrData;
    endcase
  end

  // one byte-wide bank per lane
  for (genvar l = 0; l < LANES; l++) begin : g_bank
    logic [BYTE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int w = 0; w < DEPTH; w++) begin
          store[w] <= '0;
        end
      end else if (strobe.laneEn[l]) begin
        store[idx] <= laneData[l*BYTE_W +: BYTE_W];
      end
    end

    assign rdWord[l*BYTE_W +: BYTE_W] = store[idx];
  end

  assign rdData = strobe.rdEn ? rdWord : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alignErr <= 1'b0;
    end else begin
      alignErr <= strobe.errSet;
    end
  end

endmodule

// File: rtl/lane_mem.sv
module lane_mem
  import lane_mem_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              alignErr
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int IDX_HI = IDX_W + OFS_W - 1;

  strobe_t strobe;
  logic    unusedHiAddr;

  assign unusedHiAddr = ^addr[ADDR_W-1:IDX_HI+1];

  lane_mem_ctrl u_ctrl (
    .enable  (enable),
    .mode    (mode),
    .lowAddr (addr[OFS_W-1:0]),
    .strobe  (strobe)
  );

  lane_mem_datapath #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .idx      (addr[IDX_HI:OFS_W]),
    .wrData   (wrData),
    .rdData   (rdData),
    .alignErr (alignErr)
  );

endmodule

// File: rtl/lane_mem_checker.sv
module lane_mem_checker (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic [1:0]  mode,
  input logic [31:0] addr,
  input logic [31:0] rdData,
  input logic        alignErr
);

  logic badWrite;
  assign badWrite = enable && ((mode == 2'b10 && addr[0]) ||
                               (mode == 2'b11 && addr[1:0] != 2'b00));

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> rdData == '0);                                   // R7

  AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !alignErr);                                      // R7

  AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (enable && mode != 2'b00) |-> rdData == '0);                 // R8

  AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    badWrite |=> alignErr);                                      // R6

  AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> $past(badWrite));                               // R6

endmodule

bind lane_mem lane_mem_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .mode     (mode),
  .addr     (addr),
  .rdData   (rdData),
  .alignErr (alignErr)
);

// File: tb/test_lane_mem.sv
module test_lane_mem;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  typedef struct {
    bit          isFlag;
    logic [31:0] expVal;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        alignErr;

  item_t       sbQ[$];
  logic [31:0] model [DEPTH];
  int          checks = 0;
  int          fails = 0;
  bit          finished = 0;

  lane_mem #(.DEPTH(DEPTH)) i_lane_mem (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .addr(addr), .wrData(wrData), .rdData(rdData), .alignErr(alignErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops each expectation as soon as it is queued
  initial begin
    forever begin
      item_t it;
      wait (sbQ.size() != 0);
      it = sbQ.pop_front();
      checks++;
      if (it.isFlag) begin
        if (alignErr !== it.expVal[0]) begin
          fails++;
          $display("FAIL %s alignErr actual %b expected %b", it.req, alignErr, it.expVal[0]);
        end
      end else if (rdData !== it.expVal) begin
        fails++;
        $display("FAIL %s rdData actual %h expected %h", it.req, rdData, it.expVal);
      end
    end
  end

  task automatic pushItem(bit isFlag, logic [31:0] v, string req);
    item_t it;
    it.isFlag = isFlag;
    it.expVal = v;
    it.req = req;
    sbQ.push_back(it);
    #1;
  endtask

  function automatic bit misaligned(logic [1:0] m, logic [31:0] a);
    return (m == 2'b10 && a[0]) || (m == 2'b11 && a[1:0] != 2'b00);
  endfunction

  // reference model built from R3, R4, R5, R6 and R9
  function automatic void modelWrite(logic [1:0] m, logic [31:0] a, logic [31:0] d);
    int w = int'(a[7:2]) % DEPTH;
    if (misaligned(m, a)) return;
    case (m)
      2'b01: model[w][a[1:0]*8 +: 8] = d[7:0];
      2'b10: model[w][a[1]*16 +: 16] = d[15:0];
      2'b11: model[w] = d;
      default: ;
    endcase
  endfunction

  task automatic doRead(logic [31:0] a, string req);
    @(negedge clk);
    enable = 1'b1; mode = 2'b00; addr = a; wrData = '0;
    #1;
    pushItem(0, model[int'(a[7:2]) % DEPTH], req);
  endtask

  task automatic doWrite(logic [1:0] m, logic [31:0] a, logic [31:0] d, string req);
    @(negedge clk);
    enable = 1'b1; mode = m; addr = a; wrData = d;
    #1;
    pushItem(0, 32'h0, "R8");
    modelWrite(m, a, d);
    @(negedge clk);
    pushItem(1, {31'h0, misaligned(m, a)}, req);
    enable = 1'b0;
  endtask

  task automatic idleWrite(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    enable = 1'b0; mode = 2'b11; addr = a; wrData = d;
    #1;
    pushItem(0, 32'h0, "R7");
    @(negedge clk);
    pushItem(1, 32'h0, "R7");
  endtask

  task automatic finishRun();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    pushItem(1, 32'h0, "R1");
    doRead(32'h0000_0000, "R1");
    doRead(32'h0000_00FC, "R1");

    // word write and low-bit-insensitive reads
    doWrite(2'b11, 32'h0000_0010, 32'hDEAD_BEEF, "R5");
    doRead(32'h0000_0010, "R5");
    doRead(32'h0000_0013, "R2");
    doRead(32'h0000_0011, "R2");

    // byte lanes, little-endian
    doWrite(2'b01, 32'h0000_0020, 32'hFFFF_FF11, "R3");
    doWrite(2'b01, 32'h0000_0022, 32'h0000_0033, "R3");
    doRead(32'h0000_0020, "R3");
    doWrite(2'b01, 32'h0000_0013, 32'h0000_00A5, "R3");
    doRead(32'h0000_0010, "R3");

    // halfwords
    doWrite(2'b11, 32'h0000_0030, 32'h1234_5678, "R5");
    doWrite(2'b10, 32'h0000_0030, 32'hFFFF_ABCD, "R4");
    doRead(32'h0000_0030, "R4");
    doWrite(2'b10, 32'h0000_0032, 32'h0000_9876, "R4");
    doRead(32'h0000_0030, "R4");

    // misaligned writes are dropped and flagged for one cycle
    doWrite(2'b10, 32'h0000_0031, 32'h0000_5555, "R6");
    @(negedge clk);
    pushItem(1, 32'h0, "R6");
    doRead(32'h0000_0030, "R6");
    doWrite(2'b11, 32'h0000_0012, 32'hCAFE_F00D, "R6");
    doRead(32'h0000_0010, "R6");
    doWrite(2'b11, 32'h0000_0033, 32'hCAFE_F00D, "R6");
    doRead(32'h0000_0030, "R6");

    // enable low: nothing happens
    idleWrite(32'h0000_0010, 32'h0BAD_0BAD);
    doRead(32'h0000_0010, "R7");

    // wrap of the word index
    doRead(32'h0000_0010 + DEPTH * 4, "R9");
    doWrite(2'b11, 32'hFFFF_FF00, 32'h7777_1111, "R9");
    doRead(32'h0000_0000, "R9");

    @(negedge clk);
    enable = 1'b0;
    #1;
    pushItem(0, 32'h0, "R7");
    repeat (2) @(negedge clk);
    wait (sbQ.size() == 0);
    #1;
    finishRun();
  end

endmodule